// File: doc/BRIEF.md
# Low-Leakage Stop Mode Sequencer

This block moves a small microcontroller out of run mode into one of four deep stop levels and back again. The four levels are a low-leakage stop and three very-low-leakage levels, numbered 3, 1 and 0. The core asks for a stop by raising a wait-for-interrupt indication together with a deep-sleep select and a 3-bit target mode. The sequencer then closes the peripheral clock gate, freezes the I/O pins, and lowers the power enables that the chosen level gives up. The affected supplies are two SRAM banks, a small always-on register file and the low-power oscillator.

While it is stopped, the block watches three wake sources: the wake-up unit, the NMI pin and the reset pin. The last two can each be disabled by an option bit. A wake from low-leakage stop reverses the entry steps and fires a one-cycle wake interrupt. A wake from any very-low-leakage level raises a wake reset for a fixed number of cycles. After that reset the pins stay frozen until software writes a release strobe. A sticky wake-reason field and a last-mode field are kept for software to read. The wake-reason bits are cleared by writing one to them. The wake reset does not clear either field.

FSM states: `ST_RUN`, `ST_GATE` (clock gated), `ST_HOLD` (pins frozen), `ST_STOP` (power reduced), `ST_LPWR` (low-leakage exit, power back), `ST_LREL` (low-leakage exit, pins released), `ST_VRST` (very-low-leakage exit, reset pulse). Transitions:
- run→gate on a valid deep request.
- gate→hold→stop unconditionally.
- stop→lpwr on a qualified wake when the target is low-leakage stop.
- stop→vrst on a qualified wake when the target is any very-low-leakage level.
- lpwr→lrel→run unconditionally.
- vrst→run after `RST_CYCLES` cycles.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the block is in run mode with the following outputs: clock gate open, I/O hold low, every power enable high, wake interrupt and wake reset low, `last_mode` 0 and `wake_reason` 0.
- R2: A stop is entered only when `sleep_req` and `deep_sel` are both high and `mode_sel` is a valid code. The codes are 1 for low-leakage stop, 2 for level 0, 3 for level 1 and 4 for level 3. Code 0, codes 5 to 7, and a request without `deep_sel` leave the block in run.
- R3: The cycle after an accepted request the peripheral clock gate closes. One cycle later the I/O hold rises. One cycle after that the power enables take their stop values.
- R4: While stopped, both SRAM bank enables stay high for low-leakage stop and level 3, and are low for levels 1 and 0. The register-file enable is always high.
- R5: The low-power oscillator enable is low only while stopped in level 0.
- R6: A stop ends only on `wake_evt`, on `nmi_pin` while `nmi_dis` is low, or on `rst_pin` while `rst_dis` is low. A disabled pin has no effect.
- R7: Leaving low-leakage stop takes three steps, one cycle apart. First the power enables are restored. Next the I/O hold drops. Then the clock gate opens and `wake_irq` pulses for exactly that one cycle. No wake reset is raised.
- R8: Leaving any very-low-leakage level raises `wake_reset` for `RST_CYCLES` cycles with all power restored and no `wake_irq`. The block then returns to run.
- R9: After a very-low-leakage recovery, `io_hold` stays high in run until `io_release` is strobed in run. A strobe during the wake reset has no effect.
- R10: `last_mode` takes the code of each accepted request one cycle after the request.
- R11: `wake_reason` bit 0 records the wake-up unit, bit 1 the NMI pin and bit 2 the reset pin. Each bit is set by the edge that ends a stop and survives the wake reset. Writing 1 to the matching bit of `status_clr` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sleep_req | input | 1 | Wait-for-interrupt indication from the core |
| deep_sel | input | 1 | Deep-sleep select qualifying the request |
| mode_sel | input | 3 | Target stop level code |
| wake_evt | input | 1 | Wake request from the wake-up unit |
| nmi_pin | input | 1 | NMI pin level, active high |
| rst_pin | input | 1 | Reset pin request, active high |
| nmi_dis | input | 1 | Option bit: NMI pin is not a wake source |
| rst_dis | input | 1 | Option bit: reset pin is not a wake source |
| io_release | input | 1 | Software strobe that unfreezes the pins |
| status_clr | input | 3 | Write-one-to-clear strobes for `wake_reason` |
| sram_u_pwr | output | 1 | Upper SRAM bank power enable |
| sram_l_pwr | output | 1 | Lower SRAM bank power enable |
| regfile_pwr | output | 1 | Always-on register file power enable |
| lpo_en | output | 1 | Low-power oscillator enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| io_hold | output | 1 | I/O state hold latch |
| wake_irq | output | 1 | One-cycle wake interrupt after low-leakage exit |
| wake_reset | output | 1 | Wake reset pulse after very-low-leakage exit |
| last_mode | output | 3 | Code of the last accepted stop request |
| wake_reason | output | 3 | Sticky wake source flags |

## Verification
The bench first sends out-of-range codes and shallow requests. A decoder that accepts them would gate the clock while the block should still be running. Disabled NMI and reset-pin pulses are applied in the middle of a stop; a design that ignored the option bits would wake early or set a reason bit. The bench strobes the pin release during the wake reset, which catches a hold latch that clears too early, and it separates the shrunk SRAM and oscillator enables of levels 1 and 0 from level 3. A cycle-accurate model runs alongside the design, so a swapped entry or exit step shows up one cycle early or late. So does an interrupt raised on a very-low-leakage wake, or a reason flag wiped by the wake reset.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int MODE_W  = 3;
    localparam int N_SRC   = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_RUN   = 3'd0,
        MODE_LLS   = 3'd1,
        MODE_VLLS0 = 3'd2,
        MODE_VLLS1 = 3'd3,
        MODE_VLLS3 = 3'd4
    } mode_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_GATE,
        ST_HOLD,
        ST_STOP,
        ST_LPWR,
        ST_LREL,
        ST_VRST
    } state_e;

    typedef struct packed {
        logic sram_u;
        logic sram_l;
        logic regf;
        logic lpo;
    } pwr_t;

    function automatic logic mode_valid(input logic [MODE_W-1:0] code);
        return (code >= 3'd1) && (code <= 3'd4);
    endfunction

endpackage

// File: rtl/lpm_pwr_map.sv
module lpm_pwr_map
    import lpm_pkg::*;
(
    input  logic  stopped,
    input  mode_e tgt,
    output pwr_t  pwr
);

    always_comb begin
        pwr = '{sram_u: 1'b1, sram_l: 1'b1, regf: 1'b1, lpo: 1'b1};
        if (stopped) begin
            case (tgt)
                MODE_VLLS1: begin
                    pwr.sram_u = 1'b0;
                    pwr.sram_l = 1'b0;
                end
                MODE_VLLS0: begin
                    pwr.sram_u = 1'b0;
                    pwr.sram_l = 1'b0;
                    pwr.lpo    = 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/lpm_wake.sv
module lpm_wake #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src,
    input  logic [N-1:0] src_dis,
    input  logic         sample_en,
    input  logic [N-1:0] clr,
    output logic         wake_any,
    output logic [N-1:0] reason
);

    logic [N-1:0] qual;

    assign qual     = src & ~src_dis;
    assign wake_any = |qual;

    for (genvar g = 0; g < N; g++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else begin
                flag_q <= (flag_q & ~clr[g]) | (sample_en & qual[g]);
            end
        end
        assign reason[g] = flag_q;
    end

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic              deep_sel,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              wake_any,
    input  logic              io_release,
    output logic              periph_clk_en,
    output logic              io_hold,
    output logic              wake_irq,
    output logic              wake_reset,
    output logic              stopped,
    output mode_e             tgt,
    output logic [MODE_W-1:0] last_mode
);

    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

    state_e            state_q, state_d;
    mode_e             tgt_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              hold_lat_q;
    logic              irq_q;
    logic [MODE_W-1:0] last_q;
    logic              accept;

    assign accept = sleep_req && deep_sel && mode_valid(mode_sel);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (accept) state_d = ST_GATE;
            ST_GATE: state_d = ST_HOLD;
            ST_HOLD: state_d = ST_STOP;
            ST_STOP: begin
                if (wake_any) begin
                    state_d = (tgt_q == MODE_LLS) ? ST_LPWR : ST_VRST;
                end
            end
            ST_LPWR: state_d = ST_LREL;
            ST_LREL: state_d = ST_RUN;
            ST_VRST: if (cnt_q == CNT_LAST) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q      <= MODE_RUN;
            last_q     <= '0;
            cnt_q      <= '0;
            hold_lat_q <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            irq_q <= (state_q == ST_LREL);
            cnt_q <= (state_q == ST_VRST) ? cnt_q + 1'b1 : '0;
            if (state_q == ST_RUN && accept) begin
                tgt_q  <= mode_e'(mode_sel);
                last_q <= mode_sel;
            end
            if (state_q == ST_STOP && wake_any && tgt_q != MODE_LLS) begin
                hold_lat_q <= 1'b1;
            end else if (state_q == ST_RUN && io_release) begin
                hold_lat_q <= 1'b0;
            end
        end
    end

    always_comb begin
        periph_clk_en = 1'b0;
        io_hold       = 1'b1;
        wake_reset    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                periph_clk_en = 1'b1;
                io_hold       = hold_lat_q;
            end
            ST_GATE: io_hold = hold_lat_q;
            ST_HOLD, ST_STOP, ST_LPWR: io_hold = 1'b1;
            ST_LREL: io_hold = hold_lat_q;
            ST_VRST: wake_reset = 1'b1;
            default: ;
        endcase
    end

    assign stopped   = (state_q == ST_STOP);
    assign tgt       = tgt_q;
    assign wake_irq  = irq_q;
    assign last_mode = last_q;

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sleep_req,
    input  logic        deep_sel,
    input  logic [2:0]  mode_sel,
    input  logic        wake_evt,
    input  logic        nmi_pin,
    input  logic        rst_pin,
    input  logic        nmi_dis,
    input  logic        rst_dis,
    input  logic        io_release,
    input  logic [2:0]  status_clr,
    output logic        sram_u_pwr,
    output logic        sram_l_pwr,
    output logic        regfile_pwr,
    output logic        lpo_en,
    output logic        periph_clk_en,
    output logic        io_hold,
    output logic        wake_irq,
    output logic        wake_reset,
    output logic [2:0]  last_mode,
    output logic [2:0]  wake_reason
);

    logic  wake_any;
    logic  stopped;
    mode_e tgt;
    pwr_t  pwr;

    lpm_wake #(.N(N_SRC)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       ({rst_pin, nmi_pin, wake_evt}),
        .src_dis   ({rst_dis, nmi_dis, 1'b0}),
        .sample_en (stopped),
        .clr       (status_clr),
        .wake_any  (wake_any),
        .reason    (wake_reason)
    );

    lpm_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .sleep_req     (sleep_req),
        .deep_sel      (deep_sel),
        .mode_sel      (mode_sel),
        .wake_any      (wake_any),
        .io_release    (io_release),
        .periph_clk_en (periph_clk_en),
        .io_hold       (io_hold),
        .wake_irq      (wake_irq),
        .wake_reset    (wake_reset),
        .stopped       (stopped),
        .tgt           (tgt),
        .last_mode     (last_mode)
    );

    lpm_pwr_map u_pwr (
        .stopped (stopped),
        .tgt     (tgt),
        .pwr     (pwr)
    );

    assign sram_u_pwr  = pwr.sram_u;
    assign sram_l_pwr  = pwr.sram_l;
    assign regfile_pwr = pwr.regf;
    assign lpo_en      = pwr.lpo;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wake_evt,
    input logic       nmi_pin,
    input logic       rst_pin,
    input logic       nmi_dis,
    input logic       rst_dis,
    input logic       io_release,
    input logic [2:0] status_clr,
    input logic       sram_u_pwr,
    input logic       sram_l_pwr,
    input logic       lpo_en,
    input logic       periph_clk_en,
    input logic       io_hold,
    input logic       wake_irq,
    input logic       wake_reset,
    input logic [2:0] wake_reason
);

    assert_power_after_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_u_pwr |-> (!periph_clk_en && io_hold));

    assert_lpo_only_deepest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !lpo_en |-> (!sram_u_pwr && !sram_l_pwr));

    assert_qualified_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_reset) |-> $past(wake_evt || (nmi_pin && !nmi_dis) || (rst_pin && !rst_dis)));

    assert_irq_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |=> !wake_irq);

    assert_reset_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_reset |-> (!wake_irq && !periph_clk_en && sram_u_pwr && sram_l_pwr));

    assert_hold_release_by_sw_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(io_hold) && $past(periph_clk_en)) |-> $past(io_release));

    assert_reason_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((~wake_reason) & $past(wake_reason) & ~$past(status_clr)) == 3'b000);

endmodule

bind lpm_ctrl lpm_ctrl_chk i_chk (.*);

// File: tb/test_lpm_ctrl.sv
`timescale 1ns/1ps
module test_lpm_ctrl;

    localparam int RSTC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0, deep_sel = 1'b0;
    logic [2:0] mode_sel = 3'd0;
    logic       wake_evt = 1'b0, nmi_pin = 1'b0, rst_pin = 1'b0;
    logic       nmi_dis = 1'b0, rst_dis = 1'b0, io_release = 1'b0;
    logic [2:0] status_clr = 3'd0;
    logic       sram_u_pwr, sram_l_pwr, regfile_pwr, lpo_en;
    logic       periph_clk_en, io_hold, wake_irq, wake_reset;
    logic [2:0] last_mode, wake_reason;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lpm_ctrl #(.RST_CYCLES(RSTC)) i_lpm_ctrl (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 run, 1 clock gated, 2 frozen, 3 stopped,
    // 4/5 shallow exit steps, 6 wake reset
    int m_phase, m_tgt, m_cnt, m_last, m_reason;
    bit m_hlat, m_irq;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_tgt = 0; m_cnt = 0; m_last = 0; m_reason = 0;
            m_hlat = 0; m_irq = 0;
        end else begin
            int wk;
            wk = (wake_evt ? 1 : 0) | ((nmi_pin && !nmi_dis) ? 2 : 0) | ((rst_pin && !rst_dis) ? 4 : 0);
            m_irq = (m_phase == 5);
            m_reason = m_reason & ~int'(status_clr);
            case (m_phase)
                0: begin
                    if (io_release) m_hlat = 0;
                    if (sleep_req && deep_sel && mode_sel >= 1 && mode_sel <= 4) begin
                        m_phase = 1; m_tgt = mode_sel; m_last = mode_sel;
                    end
                end
                1: m_phase = 2;
                2: m_phase = 3;
                3: if (wk != 0) begin
                    m_reason = m_reason | wk;
                    if (m_tgt == 1) m_phase = 4;
                    else begin m_phase = 6; m_cnt = 0; m_hlat = 1; end
                end
                4: m_phase = 5;
                5: m_phase = 0;
                6: if (m_cnt == RSTC - 1) m_phase = 0; else m_cnt++;
                default: m_phase = 0;
            endcase
        end
        #1;
        if (rst_n && !done) begin
            int e_hold, e_sram, e_lpo;
            e_hold = (m_phase inside {2, 3, 4, 6}) ? 1 : int'(m_hlat);
            e_sram = (m_phase == 3 && (m_tgt == 2 || m_tgt == 3)) ? 0 : 1;
            e_lpo  = (m_phase == 3 && m_tgt == 2) ? 0 : 1;
            chk("R3", "periph_clk_en", periph_clk_en, m_phase == 0);
            chk("R9", "io_hold", io_hold, e_hold);
            chk("R4", "sram_u_pwr", sram_u_pwr, e_sram);
            chk("R4", "sram_l_pwr", sram_l_pwr, e_sram);
            chk("R4", "regfile_pwr", regfile_pwr, 1);
            chk("R5", "lpo_en", lpo_en, e_lpo);
            chk("R7", "wake_irq", wake_irq, m_irq);
            chk("R8", "wake_reset", wake_reset, m_phase == 6);
            chk("R10", "last_mode", last_mode, m_last);
            chk("R11", "wake_reason", wake_reason, m_reason);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic request(input logic [2:0] code);
        sleep_req = 1; deep_sel = 1; mode_sel = code;
        cyc(1);
        sleep_req = 0; deep_sel = 0; mode_sel = 0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1 reset state
        chk("R1", "clk gate", periph_clk_en, 1);
        chk("R1", "hold", io_hold, 0);
        chk("R1", "power", {sram_u_pwr, sram_l_pwr, regfile_pwr, lpo_en}, 4'hf);
        chk("R1", "irq/reset", {wake_irq, wake_reset}, 0);
        chk("R1", "status", {last_mode, wake_reason}, 0);

        // R2 ignored requests
        foreach (ign_codes[i]) begin
            request(ign_codes[i]);
            chk("R2", "invalid code keeps run", periph_clk_en, 1);
        end
        sleep_req = 1; deep_sel = 0; mode_sel = 3'd1;
        cyc(1);
        sleep_req = 0; mode_sel = 0;
        chk("R2", "shallow request keeps run", periph_clk_en, 1);
        chk("R2", "last_mode untouched", last_mode, 0);

        // Low-leakage stop round trip
        request(3'd1);
        chk("R3", "gate closes first", {periph_clk_en, io_hold}, 2'b00);
        chk("R10", "last_mode after LLS", last_mode, 1);
        cyc(1);
        chk("R3", "hold second", io_hold, 1);
        cyc(3);
        chk("R4", "LLS keeps banks", {sram_u_pwr, sram_l_pwr}, 2'b11);
        wake_evt = 1; cyc(1); wake_evt = 0;
        chk("R7", "step1 hold kept", {periph_clk_en, io_hold, wake_reset}, 3'b010);
        cyc(1);
        chk("R7", "step2 hold released", {periph_clk_en, io_hold}, 2'b00);
        cyc(1);
        chk("R7", "step3 clock and irq", {periph_clk_en, wake_irq}, 2'b11);
        cyc(1);
        chk("R7", "irq one cycle", wake_irq, 0);
        chk("R11", "reason wake unit", wake_reason, 3'b001);
        status_clr = 3'b001; cyc(1); status_clr = 0;
        chk("R11", "W1C clears", wake_reason, 0);

        // Level 3 with NMI disabled
        nmi_dis = 1;
        request(3'd4);
        cyc(4);
        chk("R4", "VLLS3 keeps banks", {sram_u_pwr, sram_l_pwr, lpo_en}, 3'b111);
        nmi_pin = 1; cyc(2); nmi_pin = 0; cyc(1);
        chk("R6", "disabled NMI ignored", {periph_clk_en, wake_reset, wake_reason}, 0);
        rst_pin = 1; cyc(1); rst_pin = 0;
        chk("R8", "wake reset raised", {wake_reset, wake_irq}, 2'b10);
        io_release = 1; cyc(1); io_release = 0;
        cyc(RSTC - 1);
        chk("R8", "reset ended", {wake_reset, periph_clk_en}, 2'b01);
        chk("R9", "release in reset ignored", io_hold, 1);
        chk("R11", "reason reset pin survives", wake_reason, 3'b100);
        cyc(3);
        chk("R9", "hold persists in run", io_hold, 1);
        io_release = 1; cyc(1); io_release = 0;
        chk("R9", "release clears hold", io_hold, 0);
        nmi_dis = 0;

        // Level 1
        request(3'd3);
        cyc(3);
        chk("R4", "VLLS1 banks off", {sram_u_pwr, sram_l_pwr, regfile_pwr}, 3'b001);
        chk("R5", "VLLS1 lpo on", lpo_en, 1);
        wake_evt = 1; cyc(1); wake_evt = 0;
        cyc(RSTC + 1);
        io_release = 1; cyc(1); io_release = 0;

        // Level 0 with reset pin disabled
        rst_dis = 1;
        request(3'd2);
        cyc(3);
        chk("R5", "VLLS0 lpo off", lpo_en, 0);
        rst_pin = 1; cyc(2); rst_pin = 0; cyc(1);
        chk("R6", "disabled reset pin ignored", {periph_clk_en, wake_reset}, 0);
        nmi_pin = 1; cyc(1); nmi_pin = 0;
        chk("R6", "NMI wakes", wake_reset, 1);
        chk("R11", "all reasons set", wake_reason, 3'b111);
        status_clr = 3'b010; cyc(1); status_clr = 0;
        chk("R11", "clear only NMI bit", wake_reason, 3'b101);
        cyc(RSTC + 2);
        io_release = 1; cyc(1); io_release = 0;
        rst_dis = 0;
        cyc(2);
        finish_run();
    end

    logic [2:0] ign_codes [4] = '{3'd0, 3'd5, 3'd6, 3'd7};

endmodule